// File: doc/BRIEF.md
# H-Bridge Drive Decode and Fault Lockout Controller

This block decides what each half of a two-output H-bridge does on every clock cycle. The two direction inputs select high, low or off for each output. A pair of enable pins and a per-output enable bit in configuration gate that choice. Fault events can override it: overcurrent, short, overtemperature, supply undervoltage, logic-supply failure and ground loss. The block also keeps a small configuration register and a diagnostic byte. It can turn the active-low disable pin into an open-drain status flag, and in that case it reports the flag as a pulldown request.

The fault handling is a four-state machine:
- `ST_RUN`: the outputs follow the inputs.
- `ST_SUPPLY_LOW`: a non-latched lockout that ends by itself when the supply returns.
- `ST_LOCKED`: a latched lockout. It is left only through a re-enable edge.
- `ST_CFG_LOSS`: held while the logic supply is bad or ground is lost. Configuration and diagnostics are forced to defaults. When the condition clears, the machine moves to `ST_LOCKED`.

The transitions are:
- Any state goes to `ST_CFG_LOSS` on a logic-supply or ground-loss event. This has the highest priority.
- `ST_CFG_LOSS` goes to `ST_LOCKED` once that event is gone.
- `ST_RUN` or `ST_SUPPLY_LOW` goes to `ST_LOCKED` on any latching fault.
- `ST_RUN` goes to `ST_SUPPLY_LOW` on supply undervoltage.
- `ST_SUPPLY_LOW` goes to `ST_RUN` when the undervoltage ends.
- `ST_LOCKED` goes to `ST_RUN` on a re-enable edge with no fault in that cycle. If undervoltage is present at that moment, it goes to `ST_SUPPLY_LOW` instead.

Reset enters `ST_LOCKED`.

The enable pins pass through a synchronizer of `SYNC_STAGES` flops (default two) before any use. A re-enable edge is either of these, seen on the synchronized values:
- a rising EN while the effective disable is low;
- a falling effective disable while EN is high.

The effective disable is always 0 in status-flag mode.

Top module: `hb_ctrl`

## Requirements
- R1: Drive codes are 00 high-Z, 01 low, 10 high. In `ST_RUN`, with EN high, the effective disable low and the output's enable bit set, OUT1 is high when `in1`=1 and low when `in1`=0. OUT2 follows `in2` the same way. This gives forward, reverse, both-low and both-high.
- R2: An output is high-Z when synchronized EN is low, or when the disable pin is high in enable mode, or when its own configuration enable bit is clear. The configuration word is `{flag_mode, en_out2, en_out1}`, written by `cfg_wr`.
- R3: Any of these events moves the block to `ST_LOCKED`: a short to ground, a short to supply, a shorted load or overtemperature. In that state both outputs are high-Z and `lock` is 1.
- R4: `lock` clears only through a re-enable edge. Holding EN high, or raising the disable pin, leaves it set.
- R5: Supply undervoltage makes both outputs high-Z and shows 0000 in `diag[7:4]` while it lasts. It does not set `lock`. When it ends, the outputs and the previously recorded diagnostic field return.
- R6: A logic-supply or ground-loss event sets `lock`. It returns the configuration to 011, so flag mode is off and both outputs are enabled. It returns `diag` to 0xF0.
- R7: Outside flag mode, `flag_pull` is 0. In flag mode it is 1 in each of these cases:
  - EN is low;
  - the block is in `ST_LOCKED`;
  - the block is in `ST_SUPPLY_LOW` (only for as long as that lasts).

  A current-limit event never sets it.
- R8: In `diag`, bits [7:6] hold the OUT2 code and bits [5:4] the OUT1 code. The codes are:
  - 11: normal;
  - 10: short to ground;
  - 01: short to supply;
  - shorted load: OUT2=11, OUT1=00;
  - open load: OUT2=00, OUT1=11.

  Bit 3 latches overtemperature. Bit 2 latches current limit.
- R9: Priorities from high to low are shorted load, then short to ground or supply, then open load. A higher entry overwrites a lower one. A lower one never replaces a higher one.
- R10: `diag` returns to 0xF0 on a `diag_rd` pulse or on a re-enable edge. A configuration write does not clear it, and neither does clearing the enable bits.
- R11: After reset, `diag` is 0xF0, `lock` is 1, both outputs are high-Z and `flag_pull` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | Active-high enable pin, asynchronous |
| dis_pin | input | 1 | Active-low enable pin level, asynchronous |
| in1 | input | 1 | Direction input for OUT1 |
| in2 | input | 1 | Direction input for OUT2 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | {flag_mode, en_out2, en_out1} |
| ev_supply_low | input | 1 | Bridge or charge-pump supply undervoltage, level |
| ev_short_gnd | input | 2 | Per-output short to ground, [0]=OUT1 |
| ev_short_vs | input | 2 | Per-output short to supply, [0]=OUT1 |
| ev_short_load | input | 1 | Shorted load |
| ev_overtemp | input | 1 | Overtemperature shutdown |
| ev_cur_limit | input | 1 | Current-limit chop event |
| ev_open_load | input | 1 | Open-load result |
| ev_logic_supply | input | 1 | Logic supply under or over voltage |
| ev_gnd_loss | input | 1 | Ground loss |
| diag_rd | input | 1 | Valid diagnostic-read frame pulse |
| drv1 | output | 2 | OUT1 drive code |
| drv2 | output | 2 | OUT2 drive code |
| flag_pull | output | 1 | Status-flag pulldown request |
| lock | output | 1 | Lockout bit |
| diag | output | 8 | Diagnostic byte |

## Verification
A fault event presented before a clock edge changes the state and the diagnostic registers at that edge. The ports therefore show its effect one cycle later, and any check made two or more cycles later is safe. A change on an enable pin must first cross `SYNC_STAGES` flops. It gates the outputs after two edges and moves the state machine on the third. The bench therefore changes inputs on falling edges and waits four rising edges before it samples on the next falling edge. The pin sweep covers every combination of flag mode, both enable bits, EN, disable and both direction inputs, and computes each expected drive code arithmetically.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        DRV_Z  = 2'b00,
        DRV_LO = 2'b01,
        DRV_HI = 2'b10
    } drv_t;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_SUPPLY_LOW = 2'd1,
        ST_LOCKED     = 2'd2,
        ST_CFG_LOSS   = 2'd3
    } st_t;

    localparam logic [1:0] CODE_OK   = 2'b11;
    localparam logic [1:0] CODE_GND  = 2'b10;
    localparam logic [1:0] CODE_VS   = 2'b01;
    localparam logic [1:0] CODE_NONE = 2'b00;

    localparam logic [1:0] LVL_NONE  = 2'd0;
    localparam logic [1:0] LVL_OPEN  = 2'd1;
    localparam logic [1:0] LVL_SHORT = 2'd2;
    localparam logic [1:0] LVL_LOAD  = 2'd3;

    localparam logic [2:0] CFG_DEFAULT = 3'b011;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_fault_fsm.sv
module hb_fault_fsm
    import hb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reen,
    input  logic latch_fault,
    input  logic supply_low,
    input  logic cfg_loss,
    output st_t  state,
    output logic lock
);
    st_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (latch_fault)     nxt = ST_LOCKED;
                else if (supply_low) nxt = ST_SUPPLY_LOW;
            end
            ST_SUPPLY_LOW: begin
                if (latch_fault)     nxt = ST_LOCKED;
                else if (!supply_low) nxt = ST_RUN;
            end
            ST_LOCKED: begin
                if (reen && !latch_fault)
                    nxt = supply_low ? ST_SUPPLY_LOW : ST_RUN;
            end
            ST_CFG_LOSS: nxt = ST_LOCKED;
            default:     nxt = ST_LOCKED;
        endcase
        if (cfg_loss) nxt = ST_CFG_LOSS;
    end

    // Lock bit: decoded from the registered state.
    always_comb begin
        lock = (state == ST_LOCKED) || (state == ST_CFG_LOSS);
    end
endmodule

// File: rtl/hb_diag.sv
module hb_diag
    import hb_pkg::*;
#(
    parameter int NOUT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            cfg_loss,
    input  logic            supply_low,
    input  logic [NOUT-1:0] short_gnd,
    input  logic [NOUT-1:0] short_vs,
    input  logic            short_load,
    input  logic            open_load,
    input  logic            overtemp,
    input  logic            climit,
    output logic [7:0]      diag
);
    localparam int CW = 2 * NOUT;

    logic [CW-1:0] held_code, b_code, c_code, n_code;
    logic [1:0]    held_lvl, b_lvl, c_lvl, n_lvl;
    logic          ot_q, cl_q, uv_q, b_ot, b_cl, n_ot, n_cl;

    always_comb begin
        b_code = held_code;
        b_lvl  = held_lvl;
        b_ot   = ot_q;
        b_cl   = cl_q;
        if (clear || cfg_loss) begin
            b_code = '1;
            b_lvl  = LVL_NONE;
            b_ot   = 1'b0;
            b_cl   = 1'b0;
        end

        c_lvl  = LVL_NONE;
        c_code = '1;
        if (short_load) begin
            c_lvl  = LVL_LOAD;
            c_code = {CODE_OK, CODE_NONE};
        end else if ((|short_gnd) || (|short_vs)) begin
            c_lvl = LVL_SHORT;
            for (int i = 0; i < NOUT; i++)
                c_code[2*i +: 2] = short_gnd[i] ? CODE_GND :
                                   short_vs[i]  ? CODE_VS  : CODE_OK;
        end else if (open_load) begin
            c_lvl  = LVL_OPEN;
            c_code = {CODE_NONE, CODE_OK};
        end

        n_code = b_code;
        n_lvl  = b_lvl;
        n_ot   = b_ot;
        n_cl   = b_cl;
        if (!cfg_loss) begin
            if (c_lvl > b_lvl) begin
                n_code = c_code;
                n_lvl  = c_lvl;
            end else if (c_lvl == LVL_SHORT && b_lvl == LVL_SHORT) begin
                for (int i = 0; i < NOUT; i++)
                    if (short_gnd[i] || short_vs[i])
                        n_code[2*i +: 2] = c_code[2*i +: 2];
            end
            n_ot = b_ot | overtemp;
            n_cl = b_cl | climit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_code <= '1;
            held_lvl  <= LVL_NONE;
            ot_q      <= 1'b0;
            cl_q      <= 1'b0;
            uv_q      <= 1'b0;
        end else begin
            held_code <= n_code;
            held_lvl  <= n_lvl;
            ot_q      <= n_ot;
            cl_q      <= n_cl;
            uv_q      <= supply_low;
        end
    end

    assign diag = {(uv_q ? {CW{1'b0}} : held_code), ot_q, cl_q, 2'b00};
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
    import hb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_pin,
    input  logic       dis_pin,
    input  logic       in1,
    input  logic       in2,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_wdata,
    input  logic       ev_supply_low,
    input  logic [1:0] ev_short_gnd,
    input  logic [1:0] ev_short_vs,
    input  logic       ev_short_load,
    input  logic       ev_overtemp,
    input  logic       ev_cur_limit,
    input  logic       ev_open_load,
    input  logic       ev_logic_supply,
    input  logic       ev_gnd_loss,
    input  logic       diag_rd,
    output logic [1:0] drv1,
    output logic [1:0] drv2,
    output logic       flag_pull,
    output logic       lock,
    output logic [7:0] diag
);
    localparam int NOUT   = 2;
    localparam int FLAG_B = NOUT;

    logic            en_s, dis_s, en_q, dis_q;
    logic [NOUT:0]   cfg_q;
    logic            flag_mode, dis_eff, dis_eff_prev, reen;
    logic            cfg_loss, latch_fault;
    logic [NOUT-1:0] dir;
    logic [1:0]      drv [NOUT];
    st_t             state;

    hb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_en (
        .clk(clk), .rst_n(rst_n), .d(en_pin), .q(en_s));
    hb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dis (
        .clk(clk), .rst_n(rst_n), .d(dis_pin), .q(dis_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            dis_q <= 1'b1;
        end else begin
            en_q  <= en_s;
            dis_q <= dis_s;
        end
    end

    assign cfg_loss    = ev_logic_supply | ev_gnd_loss;
    assign latch_fault = (|ev_short_gnd) | (|ev_short_vs) | ev_short_load | ev_overtemp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              cfg_q <= CFG_DEFAULT;
        else if (cfg_loss || state == ST_CFG_LOSS) cfg_q <= CFG_DEFAULT;
        else if (cfg_wr)                         cfg_q <= cfg_wdata;
    end

    assign flag_mode    = cfg_q[FLAG_B];
    assign dis_eff      = flag_mode ? 1'b0 : dis_s;
    assign dis_eff_prev = flag_mode ? 1'b0 : dis_q;
    assign reen = (en_s & ~en_q & ~dis_eff) | (en_s & dis_eff_prev & ~dis_eff);

    hb_fault_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .reen(reen), .latch_fault(latch_fault),
        .supply_low(ev_supply_low), .cfg_loss(cfg_loss),
        .state(state), .lock(lock));

    hb_diag #(.NOUT(NOUT)) u_diag (
        .clk(clk), .rst_n(rst_n), .clear(diag_rd | reen), .cfg_loss(cfg_loss),
        .supply_low(ev_supply_low), .short_gnd(ev_short_gnd), .short_vs(ev_short_vs),
        .short_load(ev_short_load), .open_load(ev_open_load),
        .overtemp(ev_overtemp), .climit(ev_cur_limit), .diag(diag));

    assign dir = {in2, in1};

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        always_comb begin
            if (state == ST_RUN && en_s && !dis_eff && cfg_q[i])
                drv[i] = dir[i] ? DRV_HI : DRV_LO;
            else
                drv[i] = DRV_Z;
        end
    end

    assign drv1 = drv[0];
    assign drv2 = drv[1];

    always_comb begin
        flag_pull = flag_mode &
                    (~en_s | (state == ST_LOCKED) | (state == ST_SUPPLY_LOW));
    end
endmodule

// File: rtl/hb_ctrl_chk.sv
module hb_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_s,
    input logic       reen,
    input logic       ev_supply_low,
    input logic       ev_logic_supply,
    input logic       ev_gnd_loss,
    input logic [1:0] drv1,
    input logic [1:0] drv2,
    input logic       lock,
    input logic       flag_pull,
    input logic [7:0] diag
);
    // R3
    lock_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (drv1 == 2'b00 && drv2 == 2'b00));

    // R2
    disabled_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |-> (drv1 == 2'b00 && drv2 == 2'b00));

    // R5
    uv_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_supply_low |=> (drv1 == 2'b00 && drv2 == 2'b00 && diag[7:4] == 4'h0));

    // R6
    cfgloss_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_logic_supply || ev_gnd_loss) && !ev_supply_low)
            |=> (lock && diag == 8'hF0 && !flag_pull));

    // R4
    unlock_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> $past(reen));
endmodule

bind hb_ctrl hb_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .reen(reen),
    .ev_supply_low(ev_supply_low), .ev_logic_supply(ev_logic_supply),
    .ev_gnd_loss(ev_gnd_loss), .drv1(drv1), .drv2(drv2), .lock(lock),
    .flag_pull(flag_pull), .diag(diag));

// File: tb/tb_hb_ctrl.sv
module tb_hb_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_pin = 1'b0, dis_pin = 1'b1, in1 = 1'b0, in2 = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_wdata = 3'b011;
    logic       ev_supply_low = 1'b0, ev_short_load = 1'b0, ev_overtemp = 1'b0;
    logic [1:0] ev_short_gnd = 2'b00, ev_short_vs = 2'b00;
    logic       ev_cur_limit = 1'b0, ev_open_load = 1'b0;
    logic       ev_logic_supply = 1'b0, ev_gnd_loss = 1'b0, diag_rd = 1'b0;
    logic [1:0] drv1, drv2;
    logic       flag_pull, lock;
    logic [7:0] diag;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    hb_ctrl dut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [2:0] v);
        cfg_wdata = v; cfg_wr = 1'b1;
        settle(1);
        cfg_wr = 1'b0;
    endtask

    task automatic reenable();
        en_pin = 1'b0; settle(4);
        en_pin = 1'b1; settle(4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle(2);
        // R11 reset state
        chk("R11 diag", diag, 8'hF0);
        chk("R11 lock", {7'd0, lock}, 8'd1);
        chk("R11 drv1", {6'd0, drv1}, 8'd0);
        chk("R11 drv2", {6'd0, drv2}, 8'd0);
        chk("R11 flag", {7'd0, flag_pull}, 8'd0);

        // R4 level alone does not unlock
        dis_pin = 1'b0; settle(4);
        chk("R4 level hold", {7'd0, lock}, 8'd1);
        en_pin = 1'b1; settle(4);
        chk("R4 en rise unlock", {7'd0, lock}, 8'd0);

        // R1 R2 R7 sweep
        for (int fm = 0; fm < 2; fm++) begin
            for (int ce = 0; ce < 4; ce++) begin
                cfg_write({fm[0], ce[1:0]});
                for (int p = 0; p < 16; p++) begin
                    en_pin = p[3]; dis_pin = p[2]; in2 = p[1]; in1 = p[0];
                    settle(4);
                    begin
                        logic on1, on2;
                        on1 = p[3] & (fm[0] | ~p[2]) & ce[0];
                        on2 = p[3] & (fm[0] | ~p[2]) & ce[1];
                        chk("R1/R2 drv1", {6'd0, drv1}, on1 ? (p[0] ? 8'd2 : 8'd1) : 8'd0);
                        chk("R1/R2 drv2", {6'd0, drv2}, on2 ? (p[1] ? 8'd2 : 8'd1) : 8'd0);
                        chk("R7 sweep flag", {7'd0, flag_pull}, {7'd0, fm[0] & ~p[3]});
                    end
                end
            end
        end

        cfg_write(3'b011);
        en_pin = 1'b1; dis_pin = 1'b0; in1 = 1'b1; in2 = 1'b0;
        settle(4);
        chk("R1 forward drv1", {6'd0, drv1}, 8'd2);
        chk("R1 forward drv2", {6'd0, drv2}, 8'd1);

        // R3 R8 short to ground on OUT1
        ev_short_gnd = 2'b01; settle(1); ev_short_gnd = 2'b00; settle(1);
        chk("R3 lock", {7'd0, lock}, 8'd1);
        chk("R3 drv1", {6'd0, drv1}, 8'd0);
        chk("R8 gnd code", diag, 8'hE0);
        dis_pin = 1'b1; settle(4); dis_pin = 1'b0; settle(4);
        chk("R4 dis fall while locked en high", {7'd0, lock}, 8'd0);
        ev_overtemp = 1'b1; settle(1); ev_overtemp = 1'b0; settle(1);
        dis_pin = 1'b1; settle(4);
        chk("R4 dis rise no unlock", {7'd0, lock}, 8'd1);
        dis_pin = 1'b0; settle(4);
        diag_rd = 1'b1; settle(1); diag_rd = 1'b0; settle(1);
        chk("R10 read clear", diag, 8'hF0);

        // R9 priority
        ev_open_load = 1'b1; settle(1); ev_open_load = 1'b0; settle(1);
        chk("R8 open code", diag, 8'h30);
        chk("R8 open no lock", {7'd0, lock}, 8'd0);
        ev_short_vs = 2'b10; settle(1); ev_short_vs = 2'b00; settle(1);
        chk("R9 short over open", diag, 8'h70);
        ev_open_load = 1'b1; settle(1); ev_open_load = 1'b0; settle(1);
        chk("R9 open no overwrite", diag, 8'h70);
        ev_short_load = 1'b1; settle(1); ev_short_load = 1'b0; settle(1);
        chk("R9 load over short", diag, 8'hC0);
        cfg_write(3'b100);
        chk("R10 cfg write keeps diag", diag, 8'hC0);
        chk("R7 locked flag", {7'd0, flag_pull}, 8'd1);
        cfg_write(3'b111);

        // R5 undervoltage while locked
        ev_supply_low = 1'b1; settle(2);
        chk("R5 uv diag", diag, 8'h00);
        ev_supply_low = 1'b0; settle(2);
        chk("R5 restore", diag, 8'hC0);
        chk("R5 lock kept", {7'd0, lock}, 8'd1);
        diag_rd = 1'b1; settle(1); diag_rd = 1'b0; settle(1);
        chk("R10 read clear 2", diag, 8'hF0);
        en_pin = 1'b0; settle(4);
        chk("R7 en low flag", {7'd0, flag_pull}, 8'd1);
        en_pin = 1'b1; settle(4);
        chk("R7 en rise release", {7'd0, flag_pull}, 8'd0);
        chk("R4 flag mode unlock", {7'd0, lock}, 8'd0);

        // R5 R7 undervoltage from run
        ev_supply_low = 1'b1; settle(2);
        chk("R5 uv drv1", {6'd0, drv1}, 8'd0);
        chk("R5 uv no lock", {7'd0, lock}, 8'd0);
        chk("R7 uv flag", {7'd0, flag_pull}, 8'd1);
        ev_supply_low = 1'b0; settle(2);
        chk("R5 recover drv1", {6'd0, drv1}, 8'd2);
        chk("R7 uv flag off", {7'd0, flag_pull}, 8'd0);
        chk("R5 diag after", diag, 8'hF0);

        ev_cur_limit = 1'b1; settle(1); ev_cur_limit = 1'b0; settle(1);
        chk("R8 climit bit", diag, 8'hF4);
        chk("R7 climit no flag", {7'd0, flag_pull}, 8'd0);
        ev_overtemp = 1'b1; settle(1); ev_overtemp = 1'b0; settle(1);
        chk("R3 ot lock", {7'd0, lock}, 8'd1);
        chk("R8 ot bit", diag, 8'hFC);

        // R6 logic supply loss
        ev_logic_supply = 1'b1; settle(1); ev_logic_supply = 1'b0; settle(2);
        chk("R6 lock", {7'd0, lock}, 8'd1);
        chk("R6 diag", diag, 8'hF0);
        en_pin = 1'b0; settle(4);
        chk("R6 flag mode off", {7'd0, flag_pull}, 8'd0);
        en_pin = 1'b1; settle(4);
        chk("R6 out en default drv2", {6'd0, drv2}, 8'd1);
        chk("R6 unlock", {7'd0, lock}, 8'd0);
        ev_cur_limit = 1'b1; settle(1); ev_cur_limit = 1'b0; settle(1);
        ev_gnd_loss = 1'b1; settle(1); ev_gnd_loss = 1'b0; settle(2);
        chk("R6 gnd loss lock", {7'd0, lock}, 8'd1);
        chk("R6 gnd loss diag", diag, 8'hF0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule